// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block takes two free-running clocks, `clk_a` and `clk_b`, and passes exactly one of them to `clk_out`. The choice comes from the `sel` input, which has no timing relation to either clock. Each source has a gating leg that runs entirely in that source's own clock domain. Each leg registers its request on the rising edge of its clock and moves its output enable only on the falling edge. A leg may claim the output only after it has seen that the other leg is completely idle. As a result the old source is always released at the end of one of its high phases, and the new one is always admitted at the start of one of its low phases.

The selector serves two purposes. One is dynamic frequency scaling, where the two inputs run at different and possibly changing rates. The other is redundancy, where the output is moved from one source to the other at run time. An asynchronous active-low reset puts the output on source A at once. Each leg reports through its own domain whether its source is currently driving the output.

Top module: `ckswt_glitchless`

## Requirements
- R1: While `rst_n` is low, `act_a` is 1 and `act_b` is 0. This is forced asynchronously, without waiting for a clock edge. During reset `clk_out` follows `clk_a`, and it stays on source A after release as long as `sel` is 0.
- R2: Once a switch has settled, `sel` = 0 makes `clk_out` track `clk_a` with `act_a` = 1 and `act_b` = 0. `sel` = 1 makes `clk_out` track `clk_b` with `act_b` = 1 and `act_a` = 0.
- R3: `act_a` and `act_b` are never high together. A leg raises its status only while the other leg has no request pending and its enable is low.
- R4: Each status flag, which is also that leg's gate enable, changes only while its own clock is low, on that clock's falling edge.
- R5: After a change of `sel`, or after reset is released with `sel` = 1, the newly chosen source's status flag rises within at most three periods of the slower input clock.
- R6: No high or low phase of `clk_out` is shorter than the shorter of the two input half-periods. This also holds during a switch and when `sel` toggles faster than a switch can complete.
- R7: Writing `sel` to the value it already holds causes no change in either status flag.
- R8: After the period of the deselected input has been changed at run time, switching to that input and back behaves as in R2, R5 and R6 at the new rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock A, the reset default |
| clk_b | input | 1 | Source clock B |
| rst_n | input | 1 | Asynchronous active-low reset, selects source A |
| sel | input | 1 | Source choice: 0 selects A, 1 selects B; may change at any time |
| clk_out | output | 1 | Selected clock, free of truncated phases |
| act_a | output | 1 | Source A drives `clk_out` (changes in the `clk_a` domain) |
| act_b | output | 1 | Source B drives `clk_out` (changes in the `clk_b` domain) |

## Verification
The assertions check the safety properties continuously:
- the two status flags never overlap, and a leg is admitted only while its peer is completely idle;
- each enable moves only while its own clock is low;
- reset holds source A.

Several behaviours depend on real time across two unrelated clocks, so only the bench's scenarios can show them:
- the three-slow-cycle switchover bound;
- the minimum phase width of `clk_out`;
- the output actually tracking the chosen source.

The bench covers these across several clock ratios, a run-time period change, a repeated select, a reset taken mid-use, and a burst of select toggles faster than a switch completes.

// File: rtl/ckswt_pkg.sv
package ckswt_pkg;

  // Encoding of the select input.
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } ckswt_src_e;

  // A leg is idle only when none of its capture stages and not its enable
  // is set; the peer may claim the output only then.
  function automatic logic leg_busy(input logic any_stage, input logic enable);
    return any_stage | enable;
  endfunction

endpackage

// File: rtl/ckswt_sync.sv
module ckswt_sync #(
  parameter int unsigned DEPTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic any_set
);

  generate
    if (DEPTH == 1) begin : g_single
      logic stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
      assign q       = stg;
      assign any_set = stg;
    end else begin : g_chain
      logic [DEPTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {DEPTH{RST_VAL}};
        else        stg <= {stg[DEPTH-2:0], d};
      end
      assign q       = stg[DEPTH-1];
      assign any_set = |stg;
    end
  endgenerate

endmodule

// File: rtl/ckswt_leg.sv
module ckswt_leg
  import ckswt_pkg::*;
#(
  parameter int unsigned POS_STAGES = 1,
  parameter logic        HOME       = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic peer_busy,
  output logic en,
  output logic busy
);

  logic arm;
  logic req;
  logic pending;

  // Claim only when this source is wanted and the peer is fully idle.
  assign arm = want & ~peer_busy;

  ckswt_sync #(
    .DEPTH  (POS_STAGES),
    .RST_VAL(HOME)
  ) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (arm),
    .q      (req),
    .any_set(pending)
  );

  // Gate enable moves on the falling edge, while the source clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= HOME;
    else        en <= req;
  end

  assign busy = leg_busy(pending, en);

endmodule

// File: rtl/ckswt_glitchless.sv
module ckswt_glitchless
  import ckswt_pkg::*;
#(
  parameter int unsigned POS_STAGES = 1
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic act_a,
  output logic act_b
);

  logic want_a;
  logic want_b;
  logic en_a;
  logic en_b;
  logic busy_a;
  logic busy_b;

  assign want_b = (ckswt_src_e'(sel) == SRC_B);
  assign want_a = ~want_b;

  ckswt_leg #(
    .POS_STAGES(POS_STAGES),
    .HOME      (1'b1)
  ) u_leg_a (
    .clk      (clk_a),
    .rst_n    (rst_n),
    .want     (want_a),
    .peer_busy(busy_b),
    .en       (en_a),
    .busy     (busy_a)
  );

  ckswt_leg #(
    .POS_STAGES(POS_STAGES),
    .HOME      (1'b0)
  ) u_leg_b (
    .clk      (clk_b),
    .rst_n    (rst_n),
    .want     (want_b),
    .peer_busy(busy_a),
    .en       (en_b),
    .busy     (busy_b)
  );

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);
  assign act_a   = en_a;
  assign act_b   = en_b;

endmodule

// File: rtl/ckswt_checker.sv
module ckswt_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic act_a,
  input logic act_b,
  input logic busy_a,
  input logic busy_b
);

  logic rst_low_q = 1'b0;

  always_ff @(posedge clk_a) rst_low_q <= !rst_n;

  // R1: a reset held across a full clk_a period leaves source A in charge.
  always @(posedge clk_a) begin
    if (!rst_n && rst_low_q) begin
      p_reset_home_r1: assert (act_a && !act_b)
        else $error("p_reset_home_r1: act_a=%b act_b=%b", act_a, act_b);
    end
  end

  // R3: never both enables high, seen from each domain.
  p_exclusive_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(act_a && act_b));
  p_exclusive_b_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(act_a && act_b));

  // R3: a leg is admitted only while its peer is fully idle.
  always @(posedge act_a) begin
    if (rst_n) begin
      p_order_a_r3: assert (!act_b && !busy_b)
        else $error("p_order_a_r3: peer still busy");
    end
  end
  always @(posedge act_b) begin
    if (rst_n) begin
      p_order_b_r3: assert (!act_a && !busy_a)
        else $error("p_order_b_r3: peer still busy");
    end
  end

  // R4: enables move only while their own clock is low.
  always @(act_a) begin
    if (rst_n) begin
      p_fall_only_a_r4: assert (!clk_a)
        else $error("p_fall_only_a_r4: act_a moved with clk_a high");
    end
  end
  always @(act_b) begin
    if (rst_n) begin
      p_fall_only_b_r4: assert (!clk_b)
        else $error("p_fall_only_b_r4: act_b moved with clk_b high");
    end
  end

endmodule

bind ckswt_glitchless ckswt_checker u_chk (
  .clk_a (clk_a),
  .clk_b (clk_b),
  .rst_n (rst_n),
  .act_a (act_a),
  .act_b (act_b),
  .busy_a(busy_a),
  .busy_b(busy_b)
);

// File: tb/test_ckswt_glitchless.sv
module test_ckswt_glitchless;

  // Time unit is one tick; clk_a half-period 2500 ticks = 200 MHz at 1 ps.
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b1;
  logic sel   = 1'b0;
  wire  clk_out;
  wire  act_a;
  wire  act_b;

  int     ha = 2500;
  int     hb = 4000;
  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  bit     mon_on = 1'b0;
  longint last_edge = -1;
  longint min_phase = 64'd1 << 40;

  ckswt_glitchless i_ckswt_glitchless (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .rst_n  (rst_n),
    .sel    (sel),
    .clk_out(clk_out),
    .act_a  (act_a),
    .act_b  (act_b)
  );

  // clk_a edges fall on multiples of 500 ticks, clk_b edges 125 ticks later,
  // and bench actions at 250 mod 500, so no two events share a time step.
  initial forever begin #(ha); clk_a = ~clk_a; end
  initial begin #125; forever begin #(hb); clk_b = ~clk_b; end end

  // Phase monitor on the output clock (R6).
  always @(clk_out) begin
    if (mon_on && last_edge >= 0 && ($time - last_edge) < min_phase)
      min_phase = $time - last_edge;
    last_edge = $time;
  end

  typedef struct packed {
    logic [15:0] hb;
    logic        sel;
    logic        ea;
    logic        eb;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{hb: 16'd4000, sel: 1'b1, ea: 1'b0, eb: 1'b1},
    '{hb: 16'd4000, sel: 1'b0, ea: 1'b1, eb: 1'b0},
    '{hb: 16'd1500, sel: 1'b1, ea: 1'b0, eb: 1'b1},
    '{hb: 16'd1500, sel: 1'b0, ea: 1'b1, eb: 1'b0},
    '{hb: 16'd9000, sel: 1'b1, ea: 1'b0, eb: 1'b1},
    '{hb: 16'd9000, sel: 1'b1, ea: 1'b0, eb: 1'b1},
    '{hb: 16'd9000, sel: 1'b0, ea: 1'b1, eb: 1'b0},
    '{hb: 16'd2500, sel: 1'b1, ea: 1'b0, eb: 1'b1}
  };

  function automatic longint slow_period();
    return 2 * ((ha > hb) ? ha : hb);
  endfunction

  function automatic longint min_half();
    return (ha < hb) ? ha : hb;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic align();
    longint r = $time % 500;
    if (r != 250) #((750 - r) % 500);
  endtask

  task automatic follow_check(input string req, input bit src);
    int bad = 0;
    align();
    for (int k = 0; k < 20; k++) begin
      #1500;
      if (clk_out !== (src ? clk_b : clk_a)) bad++;
    end
    check(bad == 0, req, "clk_out tracks selected source (mismatches)", bad, 0);
  endtask

  task automatic wait_active(input bit src, input longint t0, input string req);
    longint lat;
    while (!(src ? act_b : act_a)) @(act_a or act_b);
    lat = $time - t0;
    check(lat <= 3 * slow_period(), req, "switch latency", lat, 3 * slow_period());
    check((src ? clk_b : clk_a) == 1'b0, "R4", "new enable rose with its clock low",
          src ? clk_b : clk_a, 0);
    align();
  endtask

  task automatic run_row(input row_t r);
    bit     changed;
    bit     already;
    logic   pa, pb;
    longint t0;
    string  tag;
    changed = (int'(r.hb) != hb);
    if (changed) hb = int'(r.hb);   // only ever while B is deselected
    tag = changed ? "R8" : "R2";
    min_phase = 64'd1 << 40;
    mon_on = 1'b1;
    already = r.sel ? act_b : act_a;
    pa = act_a;
    pb = act_b;
    t0 = $time;
    sel = r.sel;
    if (!already) begin
      wait_active(r.sel, t0, changed ? "R8 R5" : "R5");
    end else begin
      #(3 * slow_period());
      check(act_a == pa && act_b == pb, "R7", "flags after repeated select",
            {act_a, act_b}, {pa, pb});
    end
    #(4 * slow_period());
    check(act_a == r.ea && act_b == r.eb, tag, "status flags {a,b}",
          {act_a, act_b}, {r.ea, r.eb});
    follow_check(tag, r.sel);
    check(min_phase >= min_half(), "R6", "shortest clk_out phase", min_phase, min_half());
  endtask

  initial begin
    longint t0;
    // Reset state with sel asking for B: A must still win (R1).
    #250;
    sel   = 1'b1;
    rst_n = 1'b0;
    #20000;
    check(act_a == 1'b1, "R1", "act_a during reset", act_a, 1);
    check(act_b == 1'b0, "R1", "act_b during reset", act_b, 0);
    follow_check("R1", 1'b0);
    sel = 1'b0;
    #500;
    rst_n = 1'b1;
    #20000;
    check(act_a == 1'b1 && act_b == 1'b0, "R1", "flags after release with sel=0",
          {act_a, act_b}, 2'b10);

    // Table of ratios, repeats and run-time period changes.
    for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

    // Asynchronous reset while B drives the output (R1), then recovery (R5).
    mon_on = 1'b0;
    align();
    rst_n = 1'b0;
    #500;
    check(act_a == 1'b1 && act_b == 1'b0, "R1", "flags shortly after async reset",
          {act_a, act_b}, 2'b10);
    #5000;
    t0 = $time;
    rst_n = 1'b1;
    wait_active(1'b1, t0, "R5");
    #(4 * slow_period());
    check(act_a == 1'b0 && act_b == 1'b1, "R2", "B reacquired after reset",
          {act_a, act_b}, 2'b01);

    // Select toggles faster than a switch completes (R3, R6).
    hb = hb;
    min_phase = 64'd1 << 40;
    last_edge = -1;
    mon_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      sel = ~sel;
      #1500;
      check(!(act_a && act_b), "R3", "both flags high during toggling",
            {act_a, act_b}, 0);
    end
    sel = 1'b0;
    #(8 * slow_period());
    check(act_a == 1'b1 && act_b == 1'b0, "R2", "settled on A after toggling",
          {act_a, act_b}, 2'b10);
    check(min_phase >= min_half(), "R6", "shortest phase during toggling",
          min_phase, min_half());

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #50000000;
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule